// File: doc/BRIEF.md
# Command and Response Queue Front End

This block sits between a register bus and the transfer engine of a serial bus controller. Software feeds transfer descriptors into one command port as two 32-bit writes: an argument word, then a command word. Each completed pair goes into a command queue. Whenever the block is enabled, not halted and the engine is idle, it pops one descriptor and hands both words to the engine with a one-cycle start pulse. It then waits for the engine's done strobe before it issues the next one.

When the engine reports completion, the block can build a response word from the engine's error code and length and the command's transaction ID, and push it into a response queue that software drains through a read port. Any nonzero error halts issuing until software writes a resume request. Software can watch queue levels, program a response-count threshold that drives a ready flag, and clear each queue on its own with reset bits that clear themselves. The transmit and receive data buffers are tracked only as saturating word counts.

Register offsets: 0x00 control, 0x04 command port, 0x08 response port, 0x0C data port, 0x10 threshold, 0x14 queue levels, 0x18 data levels, 0x1C reset, 0x20 status. Read data is combinational. A read of the response or data port pops that queue.

Top module: `xq_front`

## Requirements
- R1: After reset, the level register (0x14) reads 0x00000004 (response level 0 in [15:8], command free space 4 in [7:0]), status (0x20) and control (0x00) read 0, and eng_start is low.
- R2: A command-port (0x04) write whose bits [2:0] are 1 (transfer argument) or 2 (short data argument) is held as the pending argument, and a later argument replaces it. A word with bits [2:0] of 0 (transfer command) or 3 (address assignment) pairs with the pending argument and enqueues one descriptor. A command word with no pending argument is dropped.
- R3: Control bit 31 is the enable. While it is 0 nothing is issued. While it is 1, queued descriptors are issued in write order, each as a one-cycle eng_start pulse with eng_arg and eng_cmd holding the two written words. A second descriptor is not issued before eng_done for the first.
- R4: On eng_done, a response word {eng_err[3:0], cmd[6:3], 8'h00, eng_len[15:0]} is pushed only when command bit 26 is set. For an address-assignment command, eng_len carries the count of devices left without an address.
- R5: A completion with nonzero eng_err sets status bit 1 (halted) and stops issuing. A control write with bit 30 set clears the halt, and bit 30 always reads back 0.
- R6: With threshold register (0x10) bits [15:8] holding N-1, resp_ready (also status bit 0) is high exactly when the response level is at least N.
- R7: A read of the response port (0x08) returns the oldest response and removes it. A read of an empty response queue returns 0.
- R8: Reset register (0x1C) bits clear themselves one cycle after the write, during which they read back as written. Bit 1 empties the command queue, bit 2 the response queue, bit 3 the transmit count and bit 4 the receive count. Bit 5 only clears itself. Bit 0 does all of these and also clears the halt and the pending argument.
- R9: The data-level register (0x18) shows the receive count in [15:8] and the transmit count in [7:0]. A data-port (0x0C) write raises the transmit count, saturating at 8, and eng_tx_take lowers it. eng_rx_put raises the receive count and a data-port read lowers it. Neither count goes below 0.
- R10: No descriptor is issued while the response queue is full. Issuing resumes once software reads a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops port registers) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| resp_ready | output | 1 | Response level has reached the threshold |
| eng_start | output | 1 | One-cycle start of a descriptor to the engine |
| eng_arg | output | 32 | Argument word of the issued descriptor |
| eng_cmd | output | 32 | Command word of the issued descriptor |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 4 | Completion error code (0 means none) |
| eng_len | input | 16 | Completion length or remaining device count |
| eng_tx_take | input | 1 | Engine consumed one transmit word |
| eng_rx_put | input | 1 | Engine produced one receive word |

## Verification
A software read of the response port and an engine completion that pushes a new response can land on the same clock edge. The bench provokes this by raising eng_done and the response-port read together at one falling edge while one response is already queued. The read must return the older word, the level must stay at one, and the next read must return the word built from the coinciding completion. A second overlap is a reset-register write that lands while descriptors are queued: the bench samples the reset register in the cycle where the bit is still set, then confirms that it has cleared and the queue is empty.

// File: rtl/xq_pkg.sv
package xq_pkg;

    // register offsets
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_CMD    = 8'h04;
    localparam logic [7:0] OFF_RESP   = 8'h08;
    localparam logic [7:0] OFF_DATA   = 8'h0C;
    localparam logic [7:0] OFF_THLD   = 8'h10;
    localparam logic [7:0] OFF_LEVEL  = 8'h14;
    localparam logic [7:0] OFF_DLEVEL = 8'h18;
    localparam logic [7:0] OFF_RESET  = 8'h1C;
    localparam logic [7:0] OFF_STATUS = 8'h20;

    // word attribute codes in bits [2:0]
    localparam logic [2:0] ATTR_CMD   = 3'd0;
    localparam logic [2:0] ATTR_XFER  = 3'd1;
    localparam logic [2:0] ATTR_SHORT = 3'd2;
    localparam logic [2:0] ATTR_ASSGN = 3'd3;

    localparam int CTRL_EN_BIT     = 31;
    localparam int CTRL_RESUME_BIT = 30;
    localparam int CMD_ROC_BIT     = 26;
    localparam int CMD_TID_LSB     = 3;

    localparam logic [3:0] ERR_NONE = 4'd0;

    // reset register bit positions
    localparam int RB_SOFT = 0;
    localparam int RB_CMD  = 1;
    localparam int RB_RESP = 2;
    localparam int RB_TX   = 3;
    localparam int RB_RX   = 4;
    localparam int RB_W    = 6;

    typedef enum logic {
        IS_IDLE = 1'b0,
        IS_BUSY = 1'b1
    } iss_st_e;

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] arg;
    } xq_desc_t;

endpackage

// File: rtl/xq_fifo.sv
module xq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [LW-1:0] lvl;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.lvl != '0);
        do_push = push && ((q.lvl != LW'(DEPTH)) || do_pop);
        if (clr) begin
            do_pop  = 1'b0;
            do_push = 1'b0;
            d       = '0;
        end else begin
            if (do_pop)  d.rd = wrap_inc(q.rd);
            if (do_push) d.wr = wrap_inc(q.wr);
            d.lvl = q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= wdata;
    end

    assign head  = mem[q.rd];
    assign level = q.lvl;
    assign full  = (q.lvl == LW'(DEPTH));
    assign empty = (q.lvl == '0);

endmodule

// File: rtl/xq_issue.sv
module xq_issue
    import xq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        go,
    input  logic [31:0] head_arg,
    input  logic [31:0] head_cmd,
    input  logic        eng_done,
    input  logic [3:0]  eng_err,
    input  logic [15:0] eng_len,
    output logic        pop,
    output logic        eng_start,
    output logic [31:0] eng_arg,
    output logic [31:0] eng_cmd,
    output logic        resp_push,
    output logic [31:0] resp_word,
    output logic        fault
);

    typedef struct packed {
        iss_st_e     st;
        logic        start;
        logic [31:0] arg;
        logic [31:0] cmd;
    } iss_t;

    iss_t q, d;

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        pop       = 1'b0;
        resp_push = 1'b0;
        fault     = 1'b0;
        case (q.st)
            IS_IDLE: begin
                if (go) begin
                    pop     = 1'b1;
                    d.start = 1'b1;
                    d.arg   = head_arg;
                    d.cmd   = head_cmd;
                    d.st    = IS_BUSY;
                end
            end
            IS_BUSY: begin
                if (eng_done) begin
                    d.st      = IS_IDLE;
                    resp_push = q.cmd[CMD_ROC_BIT];
                    fault     = (eng_err != ERR_NONE);
                end
            end
            default: d.st = IS_IDLE;
        endcase
        if (clr) begin
            d.st      = IS_IDLE;
            d.start   = 1'b0;
            pop       = 1'b0;
            resp_push = 1'b0;
            fault     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: IS_IDLE, start: 1'b0, arg: '0, cmd: '0};
        else        q <= d;
    end

    assign eng_start = q.start;
    assign eng_arg   = q.arg;
    assign eng_cmd   = q.cmd;
    assign resp_word = {eng_err, q.cmd[CMD_TID_LSB +: 4], 8'h00, eng_len};

endmodule

// File: rtl/xq_front.sv
module xq_front
    import xq_pkg::*;
#(
    parameter int CMD_DEPTH  = 4,
    parameter int RESP_DEPTH = 4,
    parameter int DATA_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        resp_ready,
    output logic        eng_start,
    output logic [31:0] eng_arg,
    output logic [31:0] eng_cmd,
    input  logic        eng_done,
    input  logic [3:0]  eng_err,
    input  logic [15:0] eng_len,
    input  logic        eng_tx_take,
    input  logic        eng_rx_put
);

    localparam int CLW = $clog2(CMD_DEPTH + 1);
    localparam int RLW = $clog2(RESP_DEPTH + 1);
    localparam int DLW = $clog2(DATA_DEPTH + 1);

    typedef struct packed {
        logic            en;
        logic            halted;
        logic            arg_vld;
        logic [31:0]     arg;
        logic [7:0]      thld;
        logic [RB_W-1:0] rst;
        logic [DLW-1:0]  tx;
        logic [DLW-1:0]  rx;
    } regs_t;

    regs_t q, d;

    // register decode
    logic wr_ctrl, wr_cmd, wr_data, wr_thld, wr_rst, rd_resp, rd_data;
    logic [2:0] attr;
    logic is_arg, is_cmd;

    assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
    assign wr_data = reg_wr && (reg_addr == OFF_DATA);
    assign wr_thld = reg_wr && (reg_addr == OFF_THLD);
    assign wr_rst  = reg_wr && (reg_addr == OFF_RESET);
    assign rd_resp = reg_rd && (reg_addr == OFF_RESP);
    assign rd_data = reg_rd && (reg_addr == OFF_DATA);

    assign attr   = reg_wdata[2:0];
    assign is_arg = (attr == ATTR_XFER) || (attr == ATTR_SHORT);
    assign is_cmd = (attr == ATTR_CMD) || (attr == ATTR_ASSGN);

    // queue clears from pending reset bits
    logic clr_cmd, clr_resp, clr_tx, clr_rx, clr_soft;
    assign clr_soft = q.rst[RB_SOFT];
    assign clr_cmd  = clr_soft || q.rst[RB_CMD];
    assign clr_resp = clr_soft || q.rst[RB_RESP];
    assign clr_tx   = clr_soft || q.rst[RB_TX];
    assign clr_rx   = clr_soft || q.rst[RB_RX];

    // command queue
    xq_desc_t        cmd_in, cmd_head;
    logic            cmd_push, cmd_pop, cmd_full, cmd_empty;
    logic [CLW-1:0]  cmd_lvl;

    assign cmd_in   = '{cmd: reg_wdata, arg: q.arg};
    assign cmd_push = wr_cmd && is_cmd && q.arg_vld;

    xq_fifo #(.W($bits(xq_desc_t)), .DEPTH(CMD_DEPTH)) i_cmdq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cmd),
        .push  (cmd_push),
        .wdata (cmd_in),
        .pop   (cmd_pop),
        .head  (cmd_head),
        .level (cmd_lvl),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    // response queue
    logic [31:0]    resp_word, resp_head;
    logic           resp_push, resp_pop, resp_full, resp_empty;
    logic [RLW-1:0] resp_lvl;

    assign resp_pop = rd_resp && !resp_empty;

    xq_fifo #(.W(32), .DEPTH(RESP_DEPTH)) i_respq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_resp),
        .push  (resp_push),
        .wdata (resp_word),
        .pop   (resp_pop),
        .head  (resp_head),
        .level (resp_lvl),
        .full  (resp_full),
        .empty (resp_empty)
    );

    // issue sequencer
    logic go, fault;
    assign go = q.en && !q.halted && !cmd_empty && !resp_full && (q.rst == '0);

    xq_issue i_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_soft),
        .go        (go),
        .head_arg  (cmd_head.arg),
        .head_cmd  (cmd_head.cmd),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .eng_len   (eng_len),
        .pop       (cmd_pop),
        .eng_start (eng_start),
        .eng_arg   (eng_arg),
        .eng_cmd   (eng_cmd),
        .resp_push (resp_push),
        .resp_word (resp_word),
        .fault     (fault)
    );

    // next-state logic
    logic tx_inc, tx_dec, rx_inc, rx_dec;
    assign tx_inc = wr_data && (q.tx < DLW'(DATA_DEPTH));
    assign tx_dec = eng_tx_take && (q.tx != '0);
    assign rx_inc = eng_rx_put && (q.rx < DLW'(DATA_DEPTH));
    assign rx_dec = rd_data && (q.rx != '0);

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.en = reg_wdata[CTRL_EN_BIT];
            if (reg_wdata[CTRL_RESUME_BIT]) d.halted = 1'b0;
        end
        if (fault) d.halted = 1'b1;
        if (wr_thld) d.thld = reg_wdata[15:8];
        if (wr_cmd && is_arg) begin
            d.arg     = reg_wdata;
            d.arg_vld = 1'b1;
        end else if (wr_cmd && is_cmd) begin
            d.arg_vld = 1'b0;
        end
        if (q.rst != '0)  d.rst = '0;
        else if (wr_rst)  d.rst = reg_wdata[RB_W-1:0];
        d.tx = q.tx + DLW'(tx_inc) - DLW'(tx_dec);
        d.rx = q.rx + DLW'(rx_inc) - DLW'(rx_dec);
        if (clr_tx) d.tx = '0;
        if (clr_rx) d.rx = '0;
        if (clr_soft) begin
            d.halted  = 1'b0;
            d.arg_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign resp_ready = ({1'b0, 8'(resp_lvl)} > {1'b0, q.thld});

    always_comb begin
        case (reg_addr)
            OFF_CTRL:   reg_rdata = {q.en, 31'b0};
            OFF_RESP:   reg_rdata = resp_empty ? 32'h0 : resp_head;
            OFF_THLD:   reg_rdata = {16'h0, q.thld, 8'h00};
            OFF_LEVEL:  reg_rdata = {16'h0, 8'(resp_lvl), 8'(CMD_DEPTH) - 8'(cmd_lvl)};
            OFF_DLEVEL: reg_rdata = {16'h0, 8'(q.rx), 8'(q.tx)};
            OFF_RESET:  reg_rdata = {{(32 - RB_W){1'b0}}, q.rst};
            OFF_STATUS: reg_rdata = {30'h0, q.halted, resp_ready};
            default:    reg_rdata = 32'h0;
        endcase
    end

    // observation points for the bound checker
    logic            halted_now;
    logic [RB_W-1:0] rst_pend;
    logic [DLW-1:0]  tx_cnt;
    assign halted_now = q.halted;
    assign rst_pend   = q.rst;
    assign tx_cnt     = q.tx;

endmodule

// File: rtl/xq_front_chk.sv
module xq_front_chk #(
    parameter int CMD_DEPTH  = 4,
    parameter int RESP_DEPTH = 4,
    parameter int DATA_DEPTH = 8,
    localparam int CLW = $clog2(CMD_DEPTH + 1),
    localparam int RLW = $clog2(RESP_DEPTH + 1),
    localparam int DLW = $clog2(DATA_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           eng_start,
    input logic           halted_now,
    input logic [5:0]     rst_pend,
    input logic [CLW-1:0] cmd_lvl,
    input logic [RLW-1:0] resp_lvl,
    input logic [DLW-1:0] tx_cnt
);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5
    halt_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_now |=> !eng_start);

    // R10
    resp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(resp_lvl) <= RESP_DEPTH);

    // R8
    cmd_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend[1] |=> (cmd_lvl == '0));

    // R9
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tx_cnt) <= DATA_DEPTH);

endmodule

bind xq_front xq_front_chk #(
    .CMD_DEPTH  (CMD_DEPTH),
    .RESP_DEPTH (RESP_DEPTH),
    .DATA_DEPTH (DATA_DEPTH)
) i_xq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_start  (eng_start),
    .halted_now (halted_now),
    .rst_pend   (rst_pend),
    .cmd_lvl    (cmd_lvl),
    .resp_lvl   (resp_lvl),
    .tx_cnt     (tx_cnt)
);

// File: tb/test_xq_front.sv
module test_xq_front;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00, A_CMD = 8'h04, A_RESP = 8'h08,
                           A_DATA = 8'h0C, A_THLD = 8'h10, A_LEVEL = 8'h14,
                           A_DLEVEL = 8'h18, A_RESET = 8'h1C, A_STATUS = 8'h20;
    localparam logic [31:0] EN = 32'h8000_0000, RESUME = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        resp_ready, eng_start;
    logic [31:0] eng_arg, eng_cmd;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_err = 4'h0;
    logic [15:0] eng_len = 16'h0;
    logic        eng_tx_take = 1'b0, eng_rx_put = 1'b0;

    int nvec = 0;
    int nbad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xq_front i_xq_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .resp_ready(resp_ready), .eng_start(eng_start), .eng_arg(eng_arg),
        .eng_cmd(eng_cmd), .eng_done(eng_done), .eng_err(eng_err),
        .eng_len(eng_len), .eng_tx_take(eng_tx_take), .eng_rx_put(eng_rx_put)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic look(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] c);
        wr(A_CMD, a);
        wr(A_CMD, c);
    endtask

    task automatic wait_start(output logic got, output logic [31:0] a, output logic [31:0] c);
        got = 1'b0; a = '0; c = '0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (eng_start) begin
                got = 1'b1; a = eng_arg; c = eng_cmd;
                break;
            end
        end
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (eng_start) cnt++;
        end
    endtask

    task automatic finish_xfer(input logic [3:0] e, input logic [15:0] l);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e; eng_len = l;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    function automatic logic [31:0] mkcmd(input logic [3:0] tid, input logic roc,
                                          input logic [7:0] code, input logic [2:0] at);
        return (32'(roc) << 26) | (32'h1 << 15) | (32'(code) << 7) | (32'(tid) << 3) | 32'(at);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v, a, c, w1, w2;
        logic got;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_LEVEL, v);  chk("R1 level", v, 32'h0000_0004);
        rd(A_STATUS, v); chk("R1 status", v, 32'h0);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
        chk("R1 eng_start", 32'(eng_start), 32'h0);

        // R2 pairing, enable off
        wr(A_CMD, mkcmd(4'h1, 1'b0, 8'h10, 3'd0));
        rd(A_LEVEL, v); chk("R2 lone command dropped", v, 32'h0000_0004);
        send(32'h0011_0001, 32'h0);
        wr(A_CMD, 32'h0022_0002);
        wr(A_CMD, mkcmd(4'h2, 1'b0, 8'h11, 3'd0));
        rd(A_LEVEL, v); chk("R2 pair enqueued", v, 32'h0000_0002);
        send(32'h0000_0001, mkcmd(4'h5, 1'b1, 8'h07, 3'd3));
        rd(A_LEVEL, v); chk("R2 assignment pair enqueued", v, 32'h0000_0001);
        count_starts(8, n); chk("R3 no issue while disabled", 32'(n), 32'h0);

        // R3 issue in order, one at a time
        wr(A_CTRL, EN);
        wait_start(got, a, c);
        chk("R3 first start", 32'(got), 32'h1);
        chk("R3 first arg", a, 32'h0011_0001);
        chk("R3 first cmd", c, 32'h0);
        finish_xfer(4'h0, 16'h0);
        wait_start(got, a, c);
        chk("R2 latest argument kept", a, 32'h0022_0002);
        chk("R3 second cmd", c, mkcmd(4'h2, 1'b0, 8'h11, 3'd0));
        count_starts(5, n); chk("R3 single in flight", 32'(n), 32'h0);
        finish_xfer(4'h0, 16'h0);
        wait_start(got, a, c);
        chk("R3 assignment cmd", c, mkcmd(4'h5, 1'b1, 8'h07, 3'd3));
        finish_xfer(4'h0, 16'd3);
        rd(A_RESP, v); chk("R4 remaining devices in response", v, 32'h0500_0003);
        rd(A_RESP, v); chk("R7 empty read", v, 32'h0);

        // R4/R5 sweep over tid, roc and error codes
        for (int i = 0; i < 16; i++) begin
            logic [3:0]  tid, err;
            logic        roc;
            logic [15:0] len, rlen;
            tid  = 4'(i);
            roc  = (i % 4) != 3;
            err  = 4'(i % 10);
            len  = 16'(i * 37 + 1);
            rlen = len ^ 16'h5a5a;
            send((32'(len) << 16) | 32'h1, mkcmd(tid, roc, 8'(i + 32), 3'd0));
            wait_start(got, a, c);
            chk("R3 sweep start", 32'(got), 32'h1);
            chk("R3 sweep cmd", c, mkcmd(tid, roc, 8'(i + 32), 3'd0));
            finish_xfer(err, rlen);
            if (roc) begin
                rd(A_RESP, v); chk("R4 response word", v, {err, tid, 8'h00, rlen});
            end else begin
                rd(A_LEVEL, v); chk("R4 no response without ROC", v, 32'h0000_0004);
            end
            rd(A_STATUS, v); chk("R5 halted flag", v, {30'h0, (err != 4'h0), 1'b0});
            if (err != 4'h0) begin
                wr(A_CTRL, EN | RESUME);
                rd(A_CTRL, v);   chk("R5 resume reads back 0", v, EN);
                rd(A_STATUS, v); chk("R5 halt cleared", v, 32'h0);
            end
        end

        // R5 halt blocks queued work
        send(32'h0001_0001, mkcmd(4'h3, 1'b0, 8'h01, 3'd0));
        wait_start(got, a, c);
        finish_xfer(4'd5, 16'h0);
        send(32'h0002_0001, mkcmd(4'h4, 1'b0, 8'h02, 3'd0));
        count_starts(10, n); chk("R5 no issue while halted", 32'(n), 32'h0);
        rd(A_LEVEL, v); chk("R5 command waits", v, 32'h0000_0003);
        wr(A_CTRL, EN | RESUME);
        wait_start(got, a, c); chk("R5 issue after resume", c, mkcmd(4'h4, 1'b0, 8'h02, 3'd0));
        finish_xfer(4'h0, 16'h0);

        // R6 threshold sweep
        for (int nt = 1; nt <= 4; nt++) begin
            wr(A_THLD, 32'(nt - 1) << 8);
            wr(A_RESET, 32'h4);
            @(negedge clk);
            chk("R6 empty not ready", 32'(resp_ready), 32'h0);
            for (int k = 1; k <= 4; k++) begin
                send(32'h0000_0001, mkcmd(4'(k), 1'b1, 8'h03, 3'd0));
                wait_start(got, a, c);
                finish_xfer(4'h0, 16'(k));
                chk("R6 ready flag", 32'(resp_ready), 32'(k >= nt));
            end
            rd(A_STATUS, v); chk("R6 status bit", v, 32'h1);
        end

        // R10 full response queue blocks issue
        send(32'h0000_0001, mkcmd(4'h9, 1'b1, 8'h04, 3'd0));
        count_starts(10, n); chk("R10 no issue when full", 32'(n), 32'h0);
        rd(A_RESP, v); chk("R7 oldest response", v, 32'h0100_0001);
        wait_start(got, a, c); chk("R10 issue after drain", 32'(got), 32'h1);
        finish_xfer(4'h0, 16'h0);
        wr(A_RESET, 32'h4);
        wr(A_THLD, 32'h0);

        // R7 concurrent pop and push
        send(32'h0000_0001, mkcmd(4'h1, 1'b1, 8'h05, 3'd0));
        wait_start(got, a, c);
        finish_xfer(4'h0, 16'h0111);
        w1 = 32'h0100_0111;
        w2 = 32'h0200_0222;
        send(32'h0000_0001, mkcmd(4'h2, 1'b1, 8'h06, 3'd0));
        wait_start(got, a, c);
        @(negedge clk);
        eng_done = 1'b1; eng_err = 4'h0; eng_len = 16'h0222;
        reg_addr = A_RESP; reg_rd = 1'b1;
        #1 v = reg_rdata;
        chk("R7 concurrent read gets older word", v, w1);
        @(negedge clk);
        eng_done = 1'b0; reg_rd = 1'b0;
        rd(A_LEVEL, v); chk("R7 level after overlap", v, 32'h0000_0104);
        rd(A_RESP, v);  chk("R7 newer word", v, w2);

        // R8 per-queue reset
        wr(A_CTRL, 32'h0);
        send(32'h0000_0001, mkcmd(4'h1, 1'b0, 8'h01, 3'd0));
        send(32'h0000_0001, mkcmd(4'h2, 1'b0, 8'h01, 3'd0));
        rd(A_LEVEL, v); chk("R8 queued before reset", v, 32'h0000_0002);
        wr(A_RESET, 32'h2);
        look(A_RESET, v); chk("R8 bit pending", v, 32'h2);
        rd(A_RESET, v);   chk("R8 bit self-cleared", v, 32'h0);
        rd(A_LEVEL, v);   chk("R8 command queue empty", v, 32'h0000_0004);
        wr(A_RESET, 32'h20);
        rd(A_RESET, v);   chk("R8 queue-5 bit self-cleared", v, 32'h0);

        // R9 data counts
        for (int k = 0; k < 10; k++) wr(A_DATA, 32'(k));
        rd(A_DLEVEL, v); chk("R9 tx saturates", v, 32'h0000_0008);
        @(negedge clk); eng_tx_take = 1'b1;
        repeat (3) @(negedge clk);
        eng_tx_take = 1'b0;
        eng_rx_put = 1'b1;
        repeat (2) @(negedge clk);
        eng_rx_put = 1'b0;
        rd(A_DLEVEL, v); chk("R9 counts move", v, 32'h0000_0205);
        repeat (3) rd(A_DATA, v);
        rd(A_DLEVEL, v); chk("R9 rx floor", v, 32'h0000_0005);
        wr(A_RESET, 32'h8);
        @(negedge clk);
        rd(A_DLEVEL, v); chk("R8 tx count reset", v, 32'h0);

        // R8 soft reset clears halt and pending argument
        wr(A_CTRL, EN);
        send(32'h0000_0001, mkcmd(4'h6, 1'b0, 8'h01, 3'd0));
        wait_start(got, a, c);
        finish_xfer(4'd2, 16'h0);
        wr(A_DATA, 32'h0);
        wr(A_CMD, 32'h0000_0001);
        wr(A_RESET, 32'h1);
        @(negedge clk);
        rd(A_STATUS, v); chk("R8 soft clears halt", v, 32'h0);
        rd(A_DLEVEL, v); chk("R8 soft clears counts", v, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_CMD, mkcmd(4'h7, 1'b0, 8'h01, 3'd0));
        rd(A_LEVEL, v);  chk("R8 soft drops pending argument", v, 32'h0000_0004);

        summary();
    end

endmodule